// File: doc/BRIEF.md
# Mute-interlocked mode switch sequencer

This block sits between a front-panel two-position toggle and the relay control line that selects one of two amplifier operating modes. It never passes the toggle straight through. Every accepted change is wrapped in a timed output-protection mute: the mute is raised, the relay line is switched partway through the mute, and the mute is dropped only after a settling interval. A change must still be present after a confirmation delay before it is acted on, so short glitches and contact bounce cause no mute at all.

At power-up the block holds mute, waits for the switch to settle, loads the relay line from the switch, and keeps muting for a longer interval before it releases the output. All intervals are whole milliseconds. A millisecond tick is derived from a clock-frequency parameter, so a bench can use a low clock rate and short runs. The switch input is a pulled-up line: open reads high, grounded reads low.

Top module: `mute_mode_seq`

## Requirements
- R1: The switch line passes through a two-flop synchronizer. The derived mode level equals the synchronized line (open = 1) when `MODE_INVERT` is 0, and its complement (grounded = 1) when `MODE_INVERT` is 1.
- R2: From reset, `mute` is 1. Exactly `PWR_WAIT_MS` ms after reset release the mode output is loaded from the switch, and exactly `PWR_MUTE_MS` ms after that `mute` drops to 0.
- R3: In the idle state a difference between the derived mode level and the applied mode starts a `CONFIRM_MS` ms confirmation wait; `mute` stays 0 during that wait.
- R4: If at the end of the confirmation wait the derived level equals the applied mode, the change is discarded: no mute, no mode change, return to idle.
- R5: A confirmed change raises `mute` at the end of the confirmation wait, changes `mode` `PRE_MS` ms later, and drops `mute` a further `SETTLE_MS` ms later.
- R6: `mode` changes only in a cycle in which `mute` was already 1 and remains 1.
- R7: Switch activity during power-up, confirmation, pre-switch or settle phases is ignored; the switch is evaluated again only once idle, so a difference left at the end of a sequence starts a new confirmation one cycle after `mute` drops.
- R8: The mode applied in a sequence is the level captured at the confirmation sample, even if the switch moves back before the relay change.
- R9: Asserting `rst_n` low sets `mute` to 1 and `mode` to 0 at once, without a clock edge, and restarts the power-up sequence.
- R10: One millisecond equals `CLK_HZ/1000` clock cycles; each phase lasts exactly its millisecond count times that many cycles, counted from the edge that starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_n | input | 1 | Raw pulled-up switch line, 0 when grounded |
| mute | output | 1 | Active-high output-protection mute request |
| mode | output | 1 | Registered relay mode-control level |

## Verification
The main sequence is driven with switch pulses of swept width: one cycle, two cycles, one millisecond, half and exactly the full confirmation window, which must all be rejected, and one cycle past the window, a width that reverts during the pre-switch hold and one that reverts during settling, which must all be accepted. The one-cycle step between the longest rejected and shortest accepted width pins the confirmation sample to an exact edge, and the reverting pulses separate a design that applies the captured level from one that reads the switch late, and one that re-evaluates immediately from one that reacts mid-sequence. Power-up is run with the switch both open and grounded on two instances with opposite inversion settings, which tells the polarity and invert handling apart, and an idle-state reset shows the mute rising without a clock.

// File: rtl/mmseq_pkg.sv
package mmseq_pkg;

  typedef enum logic [2:0] {
    ST_PWR_WAIT,
    ST_PWR_MUTE,
    ST_IDLE,
    ST_CONFIRM,
    ST_PRE,
    ST_SETTLE
  } seq_state_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mmseq_sync.sv
module mmseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mmseq_timer.sv
module mmseq_timer #(
  parameter int CLK_HZ = 1_000_000,
  parameter int MS_W   = 11,
  parameter int RST_MS = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] load_ms,
  output logic            expire
);

  localparam int DIV   = CLK_HZ / 1000;
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  rem;
  logic             tick;

  // prescaler restarts on every load so each phase is an exact cycle count
  assign tick   = (pre == PRE_W'(DIV - 1));
  assign expire = (rem == MS_W'(1)) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      rem <= MS_W'(RST_MS);
    end else if (load) begin
      pre <= '0;
      rem <= load_ms;
    end else if (rem != '0) begin
      if (tick) begin
        pre <= '0;
        rem <= rem - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mute_mode_seq.sv
module mute_mode_seq
  import mmseq_pkg::*;
#(
  parameter int   CLK_HZ      = 1_000_000,
  parameter logic MODE_INVERT = 1'b1,
  parameter int   PWR_WAIT_MS = 100,
  parameter int   PWR_MUTE_MS = 1500,
  parameter int   CONFIRM_MS  = 50,
  parameter int   PRE_MS      = 250,
  parameter int   SETTLE_MS   = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_n,
  output logic mute,
  output logic mode
);

  localparam int MAX_MS = max_int(max_int(max_int(PWR_WAIT_MS, PWR_MUTE_MS),
                                          max_int(CONFIRM_MS, PRE_MS)), SETTLE_MS);
  localparam int MS_W   = $clog2(MAX_MS + 1);

  seq_state_t      st_q, st_d;
  logic            mute_q, mute_d;
  logic            mode_q, mode_d;
  logic            pend_q, pend_d;
  logic            sw_s, samp;
  logic            tmr_load, tmr_done;
  logic [MS_W-1:0] tmr_ms;

  mmseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sw_n),
    .q     (sw_s)
  );

  assign samp = MODE_INVERT ? ~sw_s : sw_s;

  mmseq_timer #(.CLK_HZ(CLK_HZ), .MS_W(MS_W), .RST_MS(PWR_WAIT_MS)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_ms (tmr_ms),
    .expire  (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    mute_d   = mute_q;
    mode_d   = mode_q;
    pend_d   = pend_q;
    tmr_load = 1'b0;
    tmr_ms   = '0;
    case (st_q)
      ST_PWR_WAIT: if (tmr_done) begin
        mode_d   = samp;
        tmr_load = 1'b1;
        tmr_ms   = MS_W'(PWR_MUTE_MS);
        st_d     = ST_PWR_MUTE;
      end
      ST_PWR_MUTE: if (tmr_done) begin
        mute_d = 1'b0;
        st_d   = ST_IDLE;
      end
      ST_IDLE: if (samp != mode_q) begin
        tmr_load = 1'b1;
        tmr_ms   = MS_W'(CONFIRM_MS);
        st_d     = ST_CONFIRM;
      end
      ST_CONFIRM: if (tmr_done) begin
        if (samp != mode_q) begin
          pend_d   = samp;
          mute_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_ms   = MS_W'(PRE_MS);
          st_d     = ST_PRE;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_PRE: if (tmr_done) begin
        mode_d   = pend_q;
        tmr_load = 1'b1;
        tmr_ms   = MS_W'(SETTLE_MS);
        st_d     = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_done) begin
        mute_d = 1'b0;
        st_d   = ST_IDLE;
      end
      default: begin
        mute_d = 1'b1;
        st_d   = ST_PWR_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWR_WAIT;
      mute_q <= 1'b1;
      mode_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mute_q <= mute_d;
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign mute = mute_q;
  assign mode = mode_q;

endmodule

// File: rtl/mmseq_chk.sv
module mmseq_chk #(
  parameter int CLK_HZ      = 1_000_000,
  parameter int PWR_WAIT_MS = 100,
  parameter int PWR_MUTE_MS = 1500,
  parameter int CONFIRM_MS  = 50,
  parameter int PRE_MS      = 250,
  parameter int SETTLE_MS   = 700
) (
  input logic clk,
  input logic rst_n,
  input logic mute,
  input logic mode
);

  localparam int D = CLK_HZ / 1000;

  logic [31:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (!mute)               hi_cnt <= '0;
      else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
      if (mute)                lo_cnt <= '0;
      else if (lo_cnt != '1)   lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R6
  mode_only_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> (mute && $past(mute)));

  // R5
  mode_edge_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> ($past(hi_cnt) == 32'(PRE_MS * D - 1) ||
                        $past(hi_cnt) == 32'(PWR_WAIT_MS * D - 1)));

  // R2
  mute_release_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> ($past(hi_cnt) == 32'((PRE_MS + SETTLE_MS) * D - 1) ||
                     $past(hi_cnt) == 32'((PWR_WAIT_MS + PWR_MUTE_MS) * D - 1)));

  // R3
  mute_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> ($past(lo_cnt) >= 32'(CONFIRM_MS * D)));

  // R6
  mute_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mute)) |-> $stable(mode));

endmodule

bind mute_mode_seq mmseq_chk #(
  .CLK_HZ      (CLK_HZ),
  .PWR_WAIT_MS (PWR_WAIT_MS),
  .PWR_MUTE_MS (PWR_MUTE_MS),
  .CONFIRM_MS  (CONFIRM_MS),
  .PRE_MS      (PRE_MS),
  .SETTLE_MS   (SETTLE_MS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .mute  (mute),
  .mode  (mode)
);

// File: tb/sim_mute_mode_seq.sv
module sim_mute_mode_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4000;
  localparam int D          = CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_n = 1'b0;
  logic mute0, mode0, mute1, mode1;

  int   t = 0;
  int   checks = 0;
  int   errors = 0;
  int   restore_at = -1;
  logic restore_val = 1'b0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mute_mode_seq #(.CLK_HZ(CLK_HZ), .MODE_INVERT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_n(sw_n), .mute(mute0), .mode(mode0));

  mute_mode_seq #(.CLK_HZ(CLK_HZ), .MODE_INVERT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sw_n(sw_n), .mute(mute1), .mode(mode1));

  task automatic step();
    @(posedge clk);
    #1;
    t++;
    if (t == restore_at) sw_n = restore_val;
  endtask

  task automatic wait_to(input int n);
    while (t < n) step();
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at edge %0d", tag, act, exp, t);
    end
  endtask

  task automatic power_up(input logic lvl);
    rst_n = 1'b0;
    sw_n  = lvl;
    restore_at = -1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t = 0;
    chk("R2 mute at reset release", mute0, 1'b1);
    chk("R9 mode reset value", mode0, 1'b0);
    wait_to(PWR_W - 1);
    chk("R2 R10 mode not yet loaded", mode0, 1'b0);
    wait_to(PWR_W);
    chk("R1 inverted mode at power-up", mode0, ~lvl);
    chk("R1 plain mode at power-up", mode1, lvl);
    chk("R2 mute held after load", mute0, 1'b1);
    wait_to(PWR_T - 1);
    chk("R2 R10 mute before release", mute0, 1'b1);
    wait_to(PWR_T);
    chk("R2 R10 mute released", mute0, 1'b0);
  endtask

  localparam int PWR_W = 100 * D;
  localparam int PWR_T = 1600 * D;

  task automatic reject_pulse(input int w);
    logic m0, old, bad;
    m0 = mode0;
    old = sw_n;
    bad = 1'b0;
    t = 0;
    sw_n = ~old;
    restore_val = old;
    restore_at = w;
    while (t < 4 + 60 * D) begin
      step();
      if (mute0 !== 1'b0 || mode0 !== m0) bad = 1'b1;
    end
    restore_at = -1;
    chk($sformatf("R4 glitch of %0d cycles caused mute or mode change", w), bad, 1'b0);
    chk("R4 mode after rejected glitch", mode0, m0);
  endtask

  task automatic accept_pulse(input int w);
    logic m_old, m1_old, old;
    m_old  = mode0;
    m1_old = mode1;
    old = sw_n;
    t = 0;
    sw_n = ~old;
    restore_val = old;
    restore_at = w;
    wait_to(2 + 50 * D);
    chk("R3 no mute during confirmation", mute0, 1'b0);
    wait_to(3 + 50 * D);
    chk("R5 mute raised after confirmation", mute0, 1'b1);
    wait_to(2 + 300 * D);
    chk("R5 mode held during pre-switch", mode0, m_old);
    wait_to(3 + 300 * D);
    chk("R8 captured mode applied", mode0, ~m_old);
    chk("R1 plain instance mode applied", mode1, ~m1_old);
    chk("R6 mute still high at mode change", mute0, 1'b1);
    wait_to(2 + 1000 * D);
    chk("R5 mute held through settle", mute0, 1'b1);
    wait_to(3 + 1000 * D);
    chk("R5 mute released after settle", mute0, 1'b0);
    wait_to(3 + 1050 * D);
    chk("R7 no mute before re-evaluation confirms", mute0, 1'b0);
    wait_to(4 + 1050 * D);
    chk("R7 re-evaluated after idle", mute0, 1'b1);
    wait_to(3 + 1300 * D);
    chk("R7 mode before reverse switch", mode0, ~m_old);
    wait_to(4 + 1300 * D);
    chk("R7 mode reversed", mode0, m_old);
    wait_to(3 + 2000 * D);
    chk("R5 reverse mute held", mute0, 1'b1);
    wait_to(4 + 2000 * D);
    chk("R5 reverse mute released", mute0, 1'b0);
    restore_at = -1;
    wait_to(10 + 2000 * D);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R5 timing): actual not finished expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int rej_w[5];
    int acc_w[3];
    rej_w = '{1, 2, D, 25 * D, 50 * D};
    acc_w = '{50 * D + 1, 100 * D, 700 * D};

    power_up(1'b0);
    for (int i = 0; i < 5; i++) reject_pulse(rej_w[i]);
    for (int i = 0; i < 3; i++) accept_pulse(acc_w[i]);

    // R9: reset from idle with mode 1 and mute 0
    chk("R9 precondition mode", mode0, 1'b1);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R9 mute asserted without clock", mute0, 1'b1);
    chk("R9 mode cleared without clock", mode0, 1'b0);

    power_up(1'b1);
    reject_pulse(50 * D);
    accept_pulse(50 * D + 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule